// File: doc/BRIEF.md
# Sampling Clock Tuning Sequencer

The sequencer drives the host-side procedure that trains the receive sampling point of a card interface controller. After a start request it arms the controller's tuning logic through the register space. It narrows the interrupt enables to the buffer-read-ready source and sets up a single-block read transfer sized for the selected tuning opcode. It then issues the tuning command again and again and reads the second host control register after each command. The loop stops when the controller drops its execute-tuning bit or when the retry budget runs out.

Register traffic leaves through a valid/ready request channel with a separate read-response strobe. The tuning command leaves through its own valid/ready channel. The controller's phase search is not part of this block: the sequencer only sees its result through the two status bits it polls. At the end it judges pass or fail, cleans the control bits up on failure, restores the interrupt enables and pulses `done`.

Back-pressure rules: a request on either channel stays valid with an unchanged payload until its ready is seen high at a clock edge. Only one channel is valid at any time. A read response is a single-cycle `reg_rsp_valid` strobe that may arrive any number of cycles after the read request is accepted. The block always accepts a response and never stalls it.

Top module: `clk_tune_seq`

## Requirements
- R1: After reset, `done`, `fail`, `reg_req_valid` and `cmd_valid` are all low.
- R2: An accepted start first reads the second host control register (offset 0x3E) and then writes it back as a 16-bit write (`reg_req_wide`=0) with bit 6 (execute tuning) set and every other bit kept as read.
- R3: Next, the 32-bit value 0x00000020 (buffer-read-ready only) is written as a 32-bit write (`reg_req_wide`=1), first to offset 0x34 (status enable) and then to offset 0x38 (signal enable).
- R4: Next come three 16-bit writes: block size at 0x04 = (BND_ARG<<12) | 64, or | 128 when the opcode equals OP_HS200 and `bus_8bit` is high; block count at 0x06 = 1; transfer mode at 0x0C = 0x0010 (read direction).
- R5: Each tuning command carries `cmd_index` equal to the opcode latched at start, `cmd_arg` = 0 and `cmd_resp_kind` = 3'd1 (short response with CRC). The register and command channels are never valid together.
- R6: When the opcode equals OP_SD, the poll read request first appears GAP_CYCLES+2 cycles after the cycle in which the command is accepted. For any other opcode it appears in the next cycle, with no wait for command completion.
- R7: Every command is followed by one 16-bit poll read of 0x3E. The loop ends after the first poll that returns bit 6 clear, and in any case after MAX_TRIES commands.
- R8: The run fails if bit 6 is still set after the last allowed poll, or if bit 7 (tuned clock) is clear when the loop ends. On failure, 0x3E is written (16-bit) with bits 7 and 6 cleared and the other bits as last read.
- R9: The run ends with the 32-bit write of RESTORE_IRQ to 0x34, then the 32-bit write of 0 to 0x38. `done` then pulses for exactly one cycle. `fail` takes its verdict in the same cycle and holds it until the next accepted start, which clears it.
- R10: A start request while a run is in progress is ignored: the transaction sequence and the single `done` pulse of that run are unchanged.
- R11: A register request holds `reg_req_valid` and its payload stable until `reg_req_ready` is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tuning run (accepted only when idle) |
| tune_opcode | input | 6 | Tuning command index, latched at start |
| bus_8bit | input | 1 | Card bus is 8 bits wide, latched at start |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Verdict of the last run, held until next start |
| reg_req_valid | output | 1 | Register request valid |
| reg_req_ready | input | 1 | Register request accepted |
| reg_req_write | output | 1 | 1 = write, 0 = read |
| reg_req_wide | output | 1 | 1 = 32-bit access, 0 = 16-bit access |
| reg_req_addr | output | 8 | Register byte offset |
| reg_req_wdata | output | 32 | Write data (low half for 16-bit) |
| reg_rsp_valid | input | 1 | Read data strobe |
| reg_rsp_data | input | 16 | Read data |
| cmd_valid | output | 1 | Tuning command request valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_resp_kind | output | 3 | Expected response kind |

## Verification
The bench builds the block with MAX_TRIES = 4 and GAP_CYCLES = 3. This keeps each run short enough to sweep the whole space. The sweep covers all three opcode classes, both bus widths, every poll on which the controller can clear the execute bit (1 to 4, or never) and both values of the tuned-clock bit. The small budget makes the case where the execute bit clears on the final allowed try reachable, along with the exhausted case. Each transaction is compared with a list computed from the requirements, under ready patterns that stall both channels.

// File: rtl/tune_pkg.sv
package tune_pkg;

  localparam int unsigned REG_AW   = 8;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned HALF_DW  = 16;
  localparam int unsigned CMD_IW   = 6;

  localparam logic [REG_AW-1:0] A_HC2   = 8'h3E;
  localparam logic [REG_AW-1:0] A_IRQ_S = 8'h34;
  localparam logic [REG_AW-1:0] A_IRQ_G = 8'h38;
  localparam logic [REG_AW-1:0] A_BSZ   = 8'h04;
  localparam logic [REG_AW-1:0] A_BCNT  = 8'h06;
  localparam logic [REG_AW-1:0] A_XMODE = 8'h0C;

  localparam int unsigned BIT_EXEC  = 6;
  localparam int unsigned BIT_TUNED = 7;

  localparam logic [REG_DW-1:0]  IRQ_RD_READY = 32'h0000_0020;
  localparam logic [HALF_DW-1:0] XMODE_READ   = 16'h0010;
  localparam logic [2:0]         RESP_SHORT_CRC = 3'd1;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ARM_RD,
    S_ARM_WR,
    S_IRQS_T,
    S_IRQG_T,
    S_BSZ,
    S_BCNT,
    S_XMODE,
    S_ISSUE,
    S_GAP,
    S_POLL,
    S_JUDGE,
    S_CLR,
    S_IRQS_R,
    S_IRQG_R
  } seq_state_e;

  typedef struct packed {
    logic              wr;
    logic              wide;
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] wdata;
  } reg_op_t;

endpackage

// File: rtl/tune_step_decode.sv
module tune_step_decode
  import tune_pkg::*;
#(
  parameter logic [CMD_IW-1:0] OP_HS200    = 6'd21,
  parameter logic [2:0]        BND_ARG     = 3'd7,
  parameter logic [REG_DW-1:0] RESTORE_IRQ = 32'h007F_003B
) (
  input  seq_state_e          state,
  input  logic [HALF_DW-1:0]  hc2,
  input  logic [CMD_IW-1:0]   op,
  input  logic                bus8,
  output logic                want,
  output reg_op_t             rop
);

  localparam logic [HALF_DW-1:0] EXEC_M  = HALF_DW'(1) << BIT_EXEC;
  localparam logic [HALF_DW-1:0] TUNED_M = HALF_DW'(1) << BIT_TUNED;
  localparam logic [11:0]        SZ_STD  = 12'd64;
  localparam logic [11:0]        SZ_WIDE = 12'd128;

  logic [HALF_DW-1:0] bsz;

  always_comb begin
    bsz = {1'b0, BND_ARG, ((op == OP_HS200) && bus8) ? SZ_WIDE : SZ_STD};
  end

  always_comb begin
    want      = 1'b1;
    rop.wr    = 1'b1;
    rop.wide  = 1'b0;
    rop.addr  = A_HC2;
    rop.wdata = '0;
    unique case (state)
      S_ARM_RD: rop.wr = 1'b0;
      S_ARM_WR: rop.wdata = {16'h0, hc2 | EXEC_M};
      S_IRQS_T: begin rop.wide = 1'b1; rop.addr = A_IRQ_S; rop.wdata = IRQ_RD_READY; end
      S_IRQG_T: begin rop.wide = 1'b1; rop.addr = A_IRQ_G; rop.wdata = IRQ_RD_READY; end
      S_BSZ:    begin rop.addr = A_BSZ;   rop.wdata = {16'h0, bsz}; end
      S_BCNT:   begin rop.addr = A_BCNT;  rop.wdata = 32'd1; end
      S_XMODE:  begin rop.addr = A_XMODE; rop.wdata = {16'h0, XMODE_READ}; end
      S_POLL:   rop.wr = 1'b0;
      S_CLR:    rop.wdata = {16'h0, hc2 & ~(EXEC_M | TUNED_M)};
      S_IRQS_R: begin rop.wide = 1'b1; rop.addr = A_IRQ_S; rop.wdata = RESTORE_IRQ; end
      S_IRQG_R: begin rop.wide = 1'b1; rop.addr = A_IRQ_G; rop.wdata = '0; end
      default:  begin want = 1'b0; rop.wr = 1'b0; end
    endcase
  end

endmodule

// File: rtl/tune_reg_port.sv
module tune_reg_port
  import tune_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               want,
  input  logic               is_write,
  output logic               req_valid,
  input  logic               req_ready,
  input  logic               rsp_valid,
  input  logic [HALF_DW-1:0] rsp_data,
  output logic               step_done,
  output logic [HALF_DW-1:0] rdata
);

  logic pend_q;
  logic fire;

  assign req_valid = want && !pend_q;
  assign fire      = req_valid && req_ready;
  assign step_done = (fire && is_write) || (pend_q && rsp_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rdata  <= '0;
    end else begin
      if (fire && !is_write) begin
        pend_q <= 1'b1;
      end else if (pend_q && rsp_valid) begin
        pend_q <= 1'b0;
        rdata  <= rsp_data;
      end
    end
  end

endmodule

// File: rtl/tune_pacer.sv
module tune_pacer #(
  parameter int unsigned MAX_TRIES  = 40,
  parameter int unsigned GAP_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fire,
  output logic last_try,
  output logic gap_zero
);

  localparam int unsigned TW = $clog2(MAX_TRIES + 1);

  logic [TW-1:0] tries_q;

  assign last_try = (tries_q >= TW'(MAX_TRIES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries_q <= '0;
    end else if (clear) begin
      tries_q <= '0;
    end else if (fire && !last_try) begin
      tries_q <= tries_q + 1'b1;
    end
  end

  generate
    if (GAP_CYCLES > 0) begin : g_gap
      localparam int unsigned GW = $clog2(GAP_CYCLES + 1);
      logic [GW-1:0] gap_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          gap_q <= '0;
        end else if (fire) begin
          gap_q <= GW'(GAP_CYCLES);
        end else if (gap_q != '0) begin
          gap_q <= gap_q - 1'b1;
        end
      end
      assign gap_zero = (gap_q == '0);
    end else begin : g_nogap
      assign gap_zero = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/clk_tune_seq.sv
module clk_tune_seq
  import tune_pkg::*;
#(
  parameter int unsigned       MAX_TRIES   = 40,
  parameter int unsigned       GAP_CYCLES  = 100,
  parameter logic [5:0]        OP_SD       = 6'd19,
  parameter logic [5:0]        OP_HS200    = 6'd21,
  parameter logic [2:0]        BND_ARG     = 3'd7,
  parameter logic [31:0]       RESTORE_IRQ = 32'h007F_003B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  tune_opcode,
  input  logic        bus_8bit,
  output logic        done,
  output logic        fail,
  output logic        reg_req_valid,
  input  logic        reg_req_ready,
  output logic        reg_req_write,
  output logic        reg_req_wide,
  output logic [7:0]  reg_req_addr,
  output logic [31:0] reg_req_wdata,
  input  logic        reg_rsp_valid,
  input  logic [15:0] reg_rsp_data,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [5:0]  cmd_index,
  output logic [31:0] cmd_arg,
  output logic [2:0]  cmd_resp_kind
);

  seq_state_e st_q, st_d;
  logic [CMD_IW-1:0]  op_q;
  logic               b8_q;
  logic               fail_pend_q;
  logic               fail_q;
  logic               done_q;
  logic               want;
  reg_op_t            rop;
  logic               step_done;
  logic [HALF_DW-1:0] hc2;
  logic               cmd_fire;
  logic               start_ok;
  logic               last_try;
  logic               gap_zero;
  logic               use_gap;
  logic               run_end;

  assign start_ok  = (st_q == S_IDLE) && start;
  assign cmd_valid = (st_q == S_ISSUE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign use_gap   = (op_q == OP_SD);
  assign run_end   = (st_q == S_IRQG_R) && step_done;

  assign cmd_index     = op_q;
  assign cmd_arg       = '0;
  assign cmd_resp_kind = RESP_SHORT_CRC;

  assign reg_req_write = rop.wr;
  assign reg_req_wide  = rop.wide;
  assign reg_req_addr  = rop.addr;
  assign reg_req_wdata = rop.wdata;

  assign done = done_q;
  assign fail = fail_q;

  tune_step_decode #(
    .OP_HS200    (OP_HS200),
    .BND_ARG     (BND_ARG),
    .RESTORE_IRQ (RESTORE_IRQ)
  ) u_decode (
    .state (st_q),
    .hc2   (hc2),
    .op    (op_q),
    .bus8  (b8_q),
    .want  (want),
    .rop   (rop)
  );

  tune_reg_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (want),
    .is_write  (rop.wr),
    .req_valid (reg_req_valid),
    .req_ready (reg_req_ready),
    .rsp_valid (reg_rsp_valid),
    .rsp_data  (reg_rsp_data),
    .step_done (step_done),
    .rdata     (hc2)
  );

  tune_pacer #(
    .MAX_TRIES  (MAX_TRIES),
    .GAP_CYCLES (GAP_CYCLES)
  ) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_ok),
    .fire     (cmd_fire),
    .last_try (last_try),
    .gap_zero (gap_zero)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:   if (start)     st_d = S_ARM_RD;
      S_ARM_RD: if (step_done) st_d = S_ARM_WR;
      S_ARM_WR: if (step_done) st_d = S_IRQS_T;
      S_IRQS_T: if (step_done) st_d = S_IRQG_T;
      S_IRQG_T: if (step_done) st_d = S_BSZ;
      S_BSZ:    if (step_done) st_d = S_BCNT;
      S_BCNT:   if (step_done) st_d = S_XMODE;
      S_XMODE:  if (step_done) st_d = S_ISSUE;
      S_ISSUE:  if (cmd_fire)  st_d = use_gap ? S_GAP : S_POLL;
      S_GAP:    if (gap_zero)  st_d = S_POLL;
      S_POLL:   if (step_done) st_d = S_JUDGE;
      S_JUDGE: begin
        if (!hc2[BIT_EXEC]) st_d = hc2[BIT_TUNED] ? S_IRQS_R : S_CLR;
        else if (last_try)  st_d = S_CLR;
        else                st_d = S_ISSUE;
      end
      S_CLR:    if (step_done) st_d = S_IRQS_R;
      S_IRQS_R: if (step_done) st_d = S_IRQG_R;
      S_IRQG_R: if (step_done) st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      op_q        <= '0;
      b8_q        <= 1'b0;
      fail_pend_q <= 1'b0;
      fail_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= run_end;
      if (start_ok) begin
        op_q   <= tune_opcode;
        b8_q   <= bus_8bit;
        fail_q <= 1'b0;
      end else if (run_end) begin
        fail_q <= fail_pend_q;
      end
      if (st_q == S_JUDGE) begin
        fail_pend_q <= hc2[BIT_EXEC] || !hc2[BIT_TUNED];
      end
    end
  end

endmodule

// File: rtl/tune_seq_chk.sv
module tune_seq_chk #(
  parameter int unsigned MAX_TRIES = 40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic        fail,
  input logic        reg_req_valid,
  input logic        reg_req_ready,
  input logic        reg_req_write,
  input logic        reg_req_wide,
  input logic [7:0]  reg_req_addr,
  input logic [31:0] reg_req_wdata,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [5:0]  cmd_index
);

  localparam int unsigned CW = $clog2(MAX_TRIES + 2) + 1;

  logic [CW-1:0] fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    fired_q <= '0;
    else if (done)                 fired_q <= '0;
    else if (cmd_valid && cmd_ready) fired_q <= fired_q + 1'b1;
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid && !reg_req_ready |=> reg_req_valid && $stable(reg_req_addr) &&
      $stable(reg_req_wdata) && $stable(reg_req_write) && $stable(reg_req_wide));

  a_r5_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index));

  a_r5_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req_valid && cmd_valid));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !$past(start) |-> $stable(fail));

  a_r7_try_budget: assert property (@(posedge clk) disable iff (!rst_n)
    fired_q <= CW'(MAX_TRIES));

endmodule

bind clk_tune_seq tune_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .done          (done),
  .fail          (fail),
  .reg_req_valid (reg_req_valid),
  .reg_req_ready (reg_req_ready),
  .reg_req_write (reg_req_write),
  .reg_req_wide  (reg_req_wide),
  .reg_req_addr  (reg_req_addr),
  .reg_req_wdata (reg_req_wdata),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_index     (cmd_index)
);

// File: tb/clk_tune_seq_tb.sv
module clk_tune_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAXT = 4;
  localparam int GAPC = 3;
  localparam logic [31:0] RESTORE = 32'h007F_003B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  tune_opcode = '0;
  logic        bus_8bit = 1'b0;
  logic        done, fail;
  logic        reg_req_valid, reg_req_write, reg_req_wide;
  logic        reg_req_ready = 1'b0;
  logic [7:0]  reg_req_addr;
  logic [31:0] reg_req_wdata;
  logic        reg_rsp_valid = 1'b0;
  logic [15:0] reg_rsp_data = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic [2:0]  cmd_resp_kind;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_tune_seq #(.MAX_TRIES(MAXT), .GAP_CYCLES(GAPC)) u_dut (.*);

  int total = 0;
  int bad = 0;

  // controller model and logs
  logic [15:0] hc2;
  int cyc = 0, scen = 0;
  int clear_at = 0;
  logic tuned = 1'b0;
  logic [5:0] exp_op;
  int cmd_n, done_cnt, gap_err, field_err, hold_err, exp_gap;
  int since_cmd;
  bit armed, rsp_pend;
  logic [15:0] rsp_save;
  bit pv_r, pr_r, pv_c, pr_c;
  logic [41:0] pay_r;
  logic [5:0] pay_c;
  int n_log;
  logic [41:0] log_e [0:31];
  int n_exp;
  logic [41:0] exp_e [0:31];
  string exp_t [0:31];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      // hold checks (R11 and R5)
      if (pv_r && !pr_r && !(reg_req_valid && {reg_req_write, reg_req_wide, reg_req_addr, reg_req_wdata} == pay_r)) hold_err++;
      if (pv_c && !pr_c && !(cmd_valid && cmd_index == pay_c)) hold_err++;
      if (reg_rsp_valid) reg_rsp_valid = 1'b0;
      if (rsp_pend) begin reg_rsp_valid = 1'b1; reg_rsp_data = rsp_save; rsp_pend = 0; end
      if (armed) begin
        since_cmd++;
        if (reg_req_valid) begin
          if (since_cmd != exp_gap) gap_err++;
          armed = 0;
        end
      end
      if (done) done_cnt++;
      reg_req_ready = ((cyc + scen) % 3) != 0;
      cmd_ready     = ((cyc + scen) % 4) != 1;
      if (reg_req_valid && reg_req_ready) begin
        if (n_log < 32) log_e[n_log] = {reg_req_write, reg_req_wide, reg_req_addr, reg_req_wdata};
        n_log++;
        if (reg_req_write && reg_req_addr == 8'h3E) hc2 = reg_req_wdata[15:0];
        if (!reg_req_write) begin rsp_pend = 1; rsp_save = hc2; end
      end
      if (cmd_valid && cmd_ready) begin
        cmd_n++;
        if (cmd_index != exp_op || cmd_arg != 0 || cmd_resp_kind != 3'd1) field_err++;
        if (cmd_n == clear_at) begin hc2[6] = 1'b0; hc2[7] = tuned; end
        since_cmd = 0;
        armed = 1;
      end
      pv_r = reg_req_valid; pr_r = reg_req_ready;
      pay_r = {reg_req_write, reg_req_wide, reg_req_addr, reg_req_wdata};
      pv_c = cmd_valid; pr_c = cmd_ready; pay_c = cmd_index;
    end
  end

  task automatic add_exp(input bit w, input bit wide, input logic [7:0] a, input logic [31:0] d, input string t);
    exp_e[n_exp] = {w, wide, a, d};
    exp_t[n_exp] = t;
    n_exp++;
  endtask

  task automatic run(input logic [5:0] op, input bit b8, input int ca, input bit tu);
    int polls;
    bit xfail;
    logic [31:0] bsz;
    int waitc;
    n_log = 0; n_exp = 0; cmd_n = 0; done_cnt = 0;
    gap_err = 0; field_err = 0; hold_err = 0; armed = 0;
    clear_at = ca; tuned = tu; exp_op = op;
    exp_gap = (op == 6'd19) ? GAPC + 2 : 1;
    hc2 = 16'h0005;
    polls = (ca == 0) ? MAXT : ca;
    xfail = (ca == 0) || !tu;
    bsz = 32'h7000 | ((op == 6'd21 && b8) ? 32'd128 : 32'd64);
    add_exp(0, 0, 8'h3E, 32'h0, "R2");
    add_exp(1, 0, 8'h3E, 32'h0045, "R2");
    add_exp(1, 1, 8'h34, 32'h20, "R3");
    add_exp(1, 1, 8'h38, 32'h20, "R3");
    add_exp(1, 0, 8'h04, bsz, "R4");
    add_exp(1, 0, 8'h06, 32'd1, "R4");
    add_exp(1, 0, 8'h0C, 32'h10, "R4");
    for (int i = 0; i < polls; i++) add_exp(0, 0, 8'h3E, 32'h0, "R7");
    if (xfail) add_exp(1, 0, 8'h3E, 32'h0005, "R8");
    add_exp(1, 1, 8'h34, RESTORE, "R9");
    add_exp(1, 1, 8'h38, 32'h0, "R9");

    tune_opcode = op; bus_8bit = b8;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tune_opcode = 6'd0; bus_8bit = ~b8;
    chk(fail == 1'b0, "R9 fail cleared by start", fail, 0);
    repeat (4) @(negedge clk);
    start = 1'b1;   // R10: ignored while running
    tune_opcode = 6'd21;
    @(negedge clk);
    start = 1'b0;
    waitc = 0;
    while (done_cnt == 0 && waitc < 3000) begin @(negedge clk); waitc++; end
    chk(waitc < 3000, "R9 run finished", waitc, 3000);
    repeat (6) @(negedge clk);
    chk(done_cnt == 1, "R10 R9 single done pulse", done_cnt, 1);
    chk(fail == xfail, "R8 verdict held", fail, xfail);
    chk(cmd_n == polls, "R7 command count", cmd_n, polls);
    chk(gap_err == 0, "R6 poll spacing", gap_err, 0);
    chk(field_err == 0, "R5 command fields", field_err, 0);
    chk(hold_err == 0, "R11 request hold", hold_err, 0);
    chk(n_log == n_exp, "R7 transaction count", n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      logic [41:0] a, e;
      a = log_e[i]; e = exp_e[i];
      if (!a[41]) begin a[31:0] = '0; end
      chk(a == e, exp_t[i], a, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0 && fail == 0, "R1 reset outputs", {done, fail}, 0);
    chk(reg_req_valid == 0 && cmd_valid == 0, "R1 reset requests", {reg_req_valid, cmd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_req_valid == 0 && cmd_valid == 0 && done == 0, "R1 idle after reset", {reg_req_valid, cmd_valid, done}, 0);
    for (int o = 0; o < 3; o++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c <= MAXT; c++)
          for (int t = 0; t < 2; t++) begin
            scen++;
            run((o == 0) ? 6'd19 : (o == 1) ? 6'd21 : 6'd14, b[0], c, t[0]);
          end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule